// File: doc/BRIEF.md
# Firmware Record Loader

The loader walks a firmware image held in a byte-wide source memory and copies its contents into a target memory. The image is a packed sequence of records. Each record starts with a six-byte header: a 32-bit destination address stored least significant byte first, then a 16-bit payload length, also least significant byte first. The payload bytes follow the header. A record whose length is zero is legal and copies nothing. The next record begins directly after the last payload byte.

A pulse on `start` latches the image size and begins the walk at source offset 0. Every source read fetches one byte, and the data returns one cycle after the read request. Each payload byte goes to the target as a single byte write. The write carries the word-aligned address and a byte lane taken from the low two bits of the destination.

Before it reads a header or copies a payload, the loader checks that the whole item fits inside the image. If the check fails, the loader stops and reports the source offset of the record that failed. No byte of a failing record is written. The walk ends with a one-cycle `done` pulse, and `error` tells success apart from failure.

Top module: `fw_record_loader`

## Requirements
- R1: A record header is six bytes. Bytes 0..3 form the destination address and bytes 4..5 form the payload length, in little-endian order (byte 0 is the least significant).
- R2: Payload byte i of a record with destination D is written with one `tgt_wr` pulse. `tgt_addr` is (D+i) with its two low bits cleared, `tgt_lane` is (D+i) mod 4, and bytes are written in increasing i. Within one record, consecutive write cycles advance the lane by one, wrapping from 3 to 0.
- R3: Records are processed back to back. When the read offset equals the latched image size at a header boundary, the walk ends with `done` high and `error` low.
- R4: If fewer than six bytes remain at a header boundary, the walk ends with `done` and `error` high, and `err_offset` is that boundary's offset.
- R5: If a record's length exceeds the bytes left after its header, the walk ends with `error` high and `err_offset` equal to the record's start offset. None of that record's payload is written, and writes from earlier records stand.
- R6: A zero-length record produces no write, and processing continues with the next record.
- R7: An image size of 0 ends the walk at once, with no error and no write.
- R8: `done` is a single-cycle pulse. `busy` is high from the cycle after `start` is accepted until `done`. A `start` while busy has no effect.
- R9: After reset, `busy`, `done`, `error`, `tgt_wr` and `src_rd` are low.
- R10: Every source read address lies below the latched image size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin loading (ignored while busy) |
| image_size | input | SRC_AW+1 | Image length in bytes, latched at start |
| src_rd | output | 1 | Source byte read request |
| src_addr | output | SRC_AW | Source byte offset |
| src_data | input | 8 | Source byte, valid one cycle after src_rd |
| tgt_wr | output | 1 | Target byte write strobe |
| tgt_addr | output | DST_AW | Word-aligned target address |
| tgt_lane | output | clog2(WORD_BYTES) | Byte lane within the word |
| tgt_data | output | 8 | Byte to write |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Format error flag, valid from done until the next start |
| err_offset | output | SRC_AW+1 | Source offset of the failing record |

## Verification
Internal faults show up at the target port within a few cycles of the faulty state.
- A header byte that is mis-ordered or lost gives a wrong destination or wrong write count on the very next record.
- A read pointer that is off by one shifts every later payload byte and moves the bounds decision, which shows as a wrong `error` or `err_offset` at `done`.
- A bounds comparison off by one shows only at the exact-fit and one-byte-short images, so the sweeps step the payload offset, length and truncation one value at a time.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HCHK,
    ST_HRD,
    ST_LCHK,
    ST_PAY
  } fwl_state_t;
endpackage

// File: rtl/fwl_byte_reader.sv
module fwl_byte_reader #(
  parameter int SZ_W = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            issue,
  output logic [SZ_W-1:0] ptr,
  output logic            rd_vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      rd_vld <= 1'b0;
    end else begin
      rd_vld <= issue;
      if (load)
        ptr <= '0;
      else if (issue)
        ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/fwl_field_asm.sv
module fwl_field_asm #(
  parameter int NB = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift,
  input  logic [7:0]      byte_in,
  output logic [8*NB-1:0] fields
);
  logic [7:0] byte_q [NB];

  for (genvar k = 0; k < NB; k++) begin : g_byte
    if (k == NB - 1) begin : g_top
      always_ff @(posedge clk) begin
        if (rst)        byte_q[k] <= '0;
        else if (shift) byte_q[k] <= byte_in;
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (rst)        byte_q[k] <= '0;
        else if (shift) byte_q[k] <= byte_q[k+1];
      end
    end
    assign fields[8*k +: 8] = byte_q[k];
  end
endmodule

// File: rtl/fwl_target_port.sv
module fwl_target_port #(
  parameter int DST_AW     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [DST_AW-1:0]             dest,
  input  logic [7:0]                    data_in,
  output logic                          tgt_wr,
  output logic [DST_AW-1:0]             tgt_addr,
  output logic [$clog2(WORD_BYTES)-1:0] tgt_lane,
  output logic [7:0]                    tgt_data
);
  localparam int LANE_W = $clog2(WORD_BYTES);
  localparam logic [DST_AW-1:0] ALIGN_MASK = ~(DST_AW'(WORD_BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_wr   <= 1'b0;
      tgt_addr <= '0;
      tgt_lane <= '0;
      tgt_data <= '0;
    end else begin
      tgt_wr <= wr_en;
      if (wr_en) begin
        tgt_addr <= dest & ALIGN_MASK;
        tgt_lane <= dest[LANE_W-1:0];
        tgt_data <= data_in;
      end
    end
  end
endmodule

// File: rtl/fw_record_loader.sv
module fw_record_loader #(
  parameter int SRC_AW     = 12,
  parameter int DST_AW     = 32,
  parameter int LEN_W      = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [SRC_AW:0]               image_size,
  output logic                          src_rd,
  output logic [SRC_AW-1:0]             src_addr,
  input  logic [7:0]                    src_data,
  output logic                          tgt_wr,
  output logic [DST_AW-1:0]             tgt_addr,
  output logic [$clog2(WORD_BYTES)-1:0] tgt_lane,
  output logic [7:0]                    tgt_data,
  output logic                          busy,
  output logic                          done,
  output logic                          error,
  output logic [SRC_AW:0]               err_offset
);
  import fwl_pkg::*;

  localparam int SZ_W  = SRC_AW + 1;
  localparam int HDR_B = DST_AW / 8 + LEN_W / 8;
  localparam int HDR_W = HDR_B * 8;
  localparam int CMP_W = ((SZ_W > LEN_W) ? SZ_W : LEN_W) + 1;

  fwl_state_t        state_q;
  logic [SZ_W-1:0]   size_q;
  logic [SZ_W-1:0]   rec_start_q;
  logic [LEN_W-1:0]  iss_q;
  logic [LEN_W-1:0]  rcv_q;
  logic [DST_AW-1:0] dest_q;
  logic [SZ_W-1:0]   ptr;
  logic              rd_vld;
  logic [HDR_W-1:0]  hdr_bits;
  logic              issue;
  logic              load_ptr;
  logic [SZ_W-1:0]   remain;
  logic [CMP_W-1:0]  remain_ext;
  logic [CMP_W-1:0]  len_ext;
  logic [LEN_W-1:0]  hdr_len;
  logic [DST_AW-1:0] hdr_dest;

  assign hdr_dest   = hdr_bits[DST_AW-1:0];
  assign hdr_len    = hdr_bits[HDR_W-1 -: LEN_W];
  assign remain     = size_q - ptr;
  assign remain_ext = CMP_W'(remain);
  assign len_ext    = CMP_W'(hdr_len);
  assign load_ptr   = (state_q == ST_IDLE) && start;

  always_comb begin
    issue = 1'b0;
    if (state_q == ST_HRD && iss_q != LEN_W'(HDR_B)) issue = 1'b1;
    if (state_q == ST_PAY && iss_q != '0)            issue = 1'b1;
  end

  assign src_rd   = issue;
  assign src_addr = ptr[SRC_AW-1:0];

  fwl_byte_reader #(.SZ_W(SZ_W)) u_reader (
    .clk    (clk),
    .rst    (rst),
    .load   (load_ptr),
    .issue  (issue),
    .ptr    (ptr),
    .rd_vld (rd_vld)
  );

  fwl_field_asm #(.NB(HDR_B)) u_hdr (
    .clk     (clk),
    .rst     (rst),
    .shift   (rd_vld && state_q == ST_HRD),
    .byte_in (src_data),
    .fields  (hdr_bits)
  );

  fwl_target_port #(.DST_AW(DST_AW), .WORD_BYTES(WORD_BYTES)) u_port (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (rd_vld && state_q == ST_PAY),
    .dest     (dest_q),
    .data_in  (src_data),
    .tgt_wr   (tgt_wr),
    .tgt_addr (tgt_addr),
    .tgt_lane (tgt_lane),
    .tgt_data (tgt_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      size_q      <= '0;
      rec_start_q <= '0;
      iss_q       <= '0;
      rcv_q       <= '0;
      dest_q      <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      error       <= 1'b0;
      err_offset  <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            size_q     <= image_size;
            busy       <= 1'b1;
            error      <= 1'b0;
            err_offset <= '0;
            state_q    <= ST_HCHK;
          end
        end
        ST_HCHK: begin
          if (ptr == size_q) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else if (remain_ext < CMP_W'(HDR_B)) begin
            busy       <= 1'b0;
            done       <= 1'b1;
            error      <= 1'b1;
            err_offset <= ptr;
            state_q    <= ST_IDLE;
          end else begin
            rec_start_q <= ptr;
            iss_q       <= '0;
            rcv_q       <= '0;
            state_q     <= ST_HRD;
          end
        end
        ST_HRD: begin
          if (issue) iss_q <= iss_q + 1'b1;
          if (rd_vld) begin
            rcv_q <= rcv_q + 1'b1;
            if (rcv_q == LEN_W'(HDR_B - 1)) state_q <= ST_LCHK;
          end
        end
        ST_LCHK: begin
          if (len_ext > remain_ext) begin
            busy       <= 1'b0;
            done       <= 1'b1;
            error      <= 1'b1;
            err_offset <= rec_start_q;
            state_q    <= ST_IDLE;
          end else if (hdr_len == '0) begin
            state_q <= ST_HCHK;
          end else begin
            iss_q   <= hdr_len;
            rcv_q   <= hdr_len;
            dest_q  <= hdr_dest;
            state_q <= ST_PAY;
          end
        end
        ST_PAY: begin
          if (issue) iss_q <= iss_q - 1'b1;
          if (rd_vld) begin
            dest_q <= dest_q + 1'b1;
            rcv_q  <= rcv_q - 1'b1;
            if (rcv_q == LEN_W'(1)) state_q <= ST_HCHK;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fw_record_loader_chk.sv
module fw_record_loader_chk #(
  parameter int SRC_AW     = 12,
  parameter int WORD_BYTES = 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic [SRC_AW:0]               image_size,
  input logic                          src_rd,
  input logic [SRC_AW-1:0]             src_addr,
  input logic                          tgt_wr,
  input logic [$clog2(WORD_BYTES)-1:0] tgt_lane,
  input logic                          busy,
  input logic                          done,
  input logic                          error
);
  localparam int LANE_W = $clog2(WORD_BYTES);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_ends_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_error_at_done_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(error) |-> done);

  assert_write_while_busy_R2: assert property (@(posedge clk) disable iff (rst)
    tgt_wr |-> busy);

  assert_lane_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (tgt_wr && $past(tgt_wr)) |-> (tgt_lane == LANE_W'($past(tgt_lane) + 1'b1)));

  assert_read_in_image_R10: assert property (@(posedge clk) disable iff (rst)
    src_rd |-> ({1'b0, src_addr} < image_size));
endmodule

bind fw_record_loader fw_record_loader_chk #(
  .SRC_AW(SRC_AW), .WORD_BYTES(WORD_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .image_size(image_size), .src_rd(src_rd),
  .src_addr(src_addr), .tgt_wr(tgt_wr), .tgt_lane(tgt_lane),
  .busy(busy), .done(done), .error(error)
);

// File: tb/test_fw_record_loader.sv
`timescale 1ns/1ps
module test_fw_record_loader;
  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [AW:0] image_size = '0;
  logic        src_rd;
  logic [AW-1:0] src_addr;
  logic [7:0]  src_data = '0;
  logic        tgt_wr;
  logic [31:0] tgt_addr;
  logic [1:0]  tgt_lane;
  logic [7:0]  tgt_data;
  logic        busy, done, error;
  logic [AW:0] err_offset;

  int checks = 0;
  int errors = 0;

  logic [7:0]  mem [256];
  logic [31:0] got_a [600];
  logic [1:0]  got_l [600];
  logic [7:0]  got_d [600];
  int          got_n;
  logic [31:0] exp_a [600];
  logic [1:0]  exp_l [600];
  logic [7:0]  exp_d [600];
  int          exp_n;
  bit          exp_err;
  int          exp_off;
  bit          res_err;
  int          res_off;

  always #2.5 clk = ~clk;

  always @(posedge clk) if (src_rd) src_data <= mem[src_addr];

  fw_record_loader #(.SRC_AW(AW)) i_fw_record_loader (
    .clk(clk), .rst(rst), .start(start), .image_size(image_size),
    .src_rd(src_rd), .src_addr(src_addr), .src_data(src_data),
    .tgt_wr(tgt_wr), .tgt_addr(tgt_addr), .tgt_lane(tgt_lane),
    .tgt_data(tgt_data), .busy(busy), .done(done), .error(error),
    .err_offset(err_offset)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic put_rec(inout int p, input logic [31:0] d, input int len, input int seed);
    for (int i = 0; i < 4; i++) mem[p+i] = d[8*i +: 8];
    mem[p+4] = len[7:0];
    mem[p+5] = len[15:8];
    for (int i = 0; i < len; i++) mem[p+6+i] = 8'((seed + i * 7) & 255);
    p = p + 6 + len;
  endtask

  task automatic model(input int size);
    int p;
    int len;
    logic [31:0] d;
    p = 0; exp_n = 0; exp_err = 0; exp_off = 0;
    forever begin
      if (p == size) break;
      if (size - p < 6) begin exp_err = 1; exp_off = p; break; end
      d = {mem[p+3], mem[p+2], mem[p+1], mem[p]};
      len = {mem[p+5], mem[p+4]};
      if (len > size - p - 6) begin exp_err = 1; exp_off = p; break; end
      for (int i = 0; i < len; i++) begin
        exp_a[exp_n] = (d + 32'(i)) & 32'hFFFF_FFFC;
        exp_l[exp_n] = 2'((d + 32'(i)) & 3);
        exp_d[exp_n] = mem[p+6+i];
        exp_n++;
      end
      p = p + 6 + len;
    end
  endtask

  task automatic run(input int size, input bit restart, input string req);
    int cyc;
    bit same;
    got_n = 0;
    image_size = (AW+1)'(size);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 0;
    while (!done && cyc < 5000) begin
      if (tgt_wr) begin
        got_a[got_n] = tgt_addr; got_l[got_n] = tgt_lane; got_d[got_n] = tgt_data;
        got_n++;
      end
      if (restart && cyc == 2) chk(busy == 1'b1, "R8", "busy during walk", busy, 1);
      start = (restart && cyc == 4);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done == 1'b1, req, "done reached", done, 1);
    res_err = error; res_off = int'(err_offset);
    chk(busy == 1'b0, "R8", "busy low at done", busy, 0);
    model(size);
    chk(res_err == exp_err, req, "error flag", res_err, exp_err);
    if (exp_err) chk(res_off == exp_off, req, "err_offset", res_off, exp_off);
    chk(got_n == exp_n, req, "write count", got_n, exp_n);
    same = (got_n == exp_n);
    for (int i = 0; i < got_n && i < exp_n; i++)
      if (got_a[i] != exp_a[i] || got_l[i] != exp_l[i] || got_d[i] != exp_d[i]) begin
        same = 0;
        $display("FAIL %s write %0d: actual %h/%0d/%h expected %h/%0d/%h", req, i,
                 got_a[i], got_l[i], got_d[i], exp_a[i], exp_l[i], exp_d[i]);
      end
    chk(same, "R2", "write contents", got_n, exp_n);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done one cycle", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int p;
    for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && error == 0, "R9", "status after reset",
        {busy, done, error}, 0);
    chk(tgt_wr == 0 && src_rd == 0, "R9", "strobes after reset", {tgt_wr, src_rd}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 R6: three records incl. zero length and high unaligned dest, restart ignored
    p = 0;
    put_rec(p, 32'h0000_0100, 5, 3);
    put_rec(p, 32'h0000_0203, 0, 0);
    put_rec(p, 32'h8000_0FFE, 7, 91);
    run(p, 1'b1, "R1");

    // R7: empty image
    run(0, 1'b0, "R7");

    // R4: three stray bytes after a good record
    p = 0;
    put_rec(p, 32'h0000_0040, 4, 17);
    run(p + 3, 1'b0, "R4");

    // R5: second record overruns the image
    p = 0;
    put_rec(p, 32'h0000_0010, 3, 5);
    put_rec(p, 32'h0000_0500, 20, 33);
    run(p - 10, 1'b0, "R5");

    // R3 R2: sweep start lane and length, exact fit
    for (int off = 0; off < 4; off++)
      for (int len = 0; len < 9; len++) begin
        p = 0;
        put_rec(p, 32'h0000_1000 + 32'(off), len, off * 13 + len);
        run(p, 1'b0, "R3");
      end

    // R5: sweep payload truncation by 1..4 bytes
    for (int cut = 1; cut < 5; cut++) begin
      p = 0;
      put_rec(p, 32'h0000_2001, 5, cut);
      run(p - cut, 1'b0, "R5");
    end

    // R4: sweep short headers of 1..5 bytes after one good record
    for (int rem = 1; rem < 6; rem++) begin
      p = 0;
      put_rec(p, 32'h0000_3002, 2, rem);
      run(p + rem, 1'b0, "R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule